// File: doc/BRIEF.md
# Indexed Byte-Memory Access Port with Region Locks

This block gives a host byte-wide access to a larger byte memory through a four-slot port. Two slots load the low and high bytes of a 16-bit pointer. A third slot is the data window: a write there stores a byte at the pointed location, and a read returns the byte held there. The memory has a parameterised depth and sits inside the block. Reset leaves its contents as they are.

Two lock bits each guard a 16-byte region near the bottom of the memory. A separate toggle input flips one lock bit at a time. While a region is locked, reads through the data window return all ones and writes are discarded. Pointer values at or beyond the memory depth behave the same way. The pointer drops back to zero after every data-window write, so a host must load an address again before each store.

Top module: `nvram_index_port`

## Requirements
- R1: A write with `portSel` = 0 replaces bits 7:0 of the pointer with `wrData`. A write with `portSel` = 1 replaces bits 15:8. The other half is kept.
- R2: A write with `portSel` = 3 stores `wrData` at the pointed byte on that clock edge. At the same edge the pointer becomes 0x0000.
- R3: With `portSel` = 3, `rdData` shows the byte at the pointer combinationally. With `portSel` = 0, 1 or 2, `rdData` is 0xFF.
- R4: A write with `portSel` = 2 changes neither the pointer nor any memory byte.
- R5: While lock bit 0 is set, pointers 0x20..0x2F are protected. While lock bit 1 is set, pointers 0x30..0x3F are protected. Reads of a protected byte give 0xFF. Writes to it are dropped, but they still clear the pointer. Addresses just outside a window are not affected.
- R6: In a cycle with `lockToggle` high, lock bit `lockIdx` is inverted at the clock edge. A second toggle of the same bit restores it.
- R7: Reset (`rstN` low) clears the pointer and both lock bits.
- R8: A pointer at or above MEM_BYTES reads 0xFF and ignores writes. Such a write does not wrap onto a low address.
- R9: Reading through `portSel` = 3 leaves the pointer unchanged.
- R10: Reset does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| portSel | input | 2 | Port slot: 0 = pointer low, 1 = pointer high, 2 = unused, 3 = data |
| wrEn | input | 1 | Write strobe for the selected slot |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte for the selected slot |
| lockToggle | input | 1 | Flip the lock bit chosen by lockIdx |
| lockIdx | input | 1 | Which lock bit to flip |

## Verification
The hardest state to reach is a dropped write to a locked region, followed by proof that the region's old contents survived. The pointer is cleared after every store, and the locked byte reads as 0xFF, so the port cannot show either fact directly. The stimulus first stores known bytes in both windows and just beside them. It then locks a window, attempts an overwrite, reads address zero without reloading the pointer, and unlocks again with a second toggle. At that point the original byte must be visible. Reset is applied while a lock is set and the pointer is non-zero, which shows the cleared state and the kept memory in one pass.

// File: rtl/nvram_port_pkg.sv
package nvram_port_pkg;
  localparam int PTR_W = 16;
  localparam logic [1:0] SEL_LO   = 2'd0;
  localparam logic [1:0] SEL_HI   = 2'd1;
  localparam logic [1:0] SEL_NONE = 2'd2;
  localparam logic [1:0] SEL_DATA = 2'd3;

  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic store;
    logic clearPtr;
    logic blockRead;
  } portStrobe_t;
endpackage

// File: rtl/nvram_port_ctrl.sv
module nvram_port_ctrl
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int LIDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           portSel,
  input  logic                 wrEn,
  input  logic [PTR_W-1:0]     ptrQ,
  input  logic                 lockToggle,
  input  logic [LIDX_W-1:0]    lockIdx,
  output logic [NUM_LOCKS-1:0] lockQ,
  output portStrobe_t          strobe
);
  logic [31:0]          ptrExt;
  logic [NUM_LOCKS-1:0] winHit;
  logic                 inRange;
  logic                 blocked;

  assign ptrExt = 32'(ptrQ);

  // lock bits flip on request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ <= '0;
    end else if (lockToggle && (int'(lockIdx) < NUM_LOCKS)) begin
      lockQ[lockIdx] <= ~lockQ[lockIdx];
    end
  end

  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_win
    localparam int LO = LOCK_BASE + i * LOCK_SPAN;
    localparam int HI = LO + LOCK_SPAN;
    assign winHit[i] = lockQ[i] && (ptrExt >= 32'(LO)) && (ptrExt < 32'(HI));
  end

  assign inRange = ptrExt < 32'(MEM_BYTES);
  assign blocked = (|winHit) || !inRange;

  always_comb begin
    strobe           = '0;
    strobe.loadLo    = wrEn && (portSel == SEL_LO);
    strobe.loadHi    = wrEn && (portSel == SEL_HI);
    strobe.clearPtr  = wrEn && (portSel == SEL_DATA);
    strobe.store     = strobe.clearPtr && !blocked;
    strobe.blockRead = blocked;
  end
endmodule

// File: rtl/nvram_port_dp.sv
module nvram_port_dp
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  localparam int IDX_W = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       portSel,
  input  logic [7:0]       wrData,
  input  portStrobe_t      strobe,
  output logic [PTR_W-1:0] ptrQ,
  output logic [7:0]       rdData
);
  logic [7:0]       mem [MEM_BYTES];
  logic [IDX_W-1:0] memIdx;

  assign memIdx = ptrQ[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strobe.clearPtr) begin
      ptrQ <= '0;
    end else begin
      if (strobe.loadLo) ptrQ[7:0]       <= wrData;
      if (strobe.loadHi) ptrQ[PTR_W-1:8] <= wrData;
    end
  end

  // contents survive reset
  always_ff @(posedge clk) begin
    if (strobe.store) mem[memIdx] <= wrData;
  end

  assign rdData = ((portSel == SEL_DATA) && !strobe.blockRead) ? mem[memIdx] : 8'hFF;
endmodule

// File: rtl/nvram_index_port.sv
module nvram_index_port
  import nvram_port_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16,
  localparam int LIDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        portSel,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              lockToggle,
  input  logic [LIDX_W-1:0] lockIdx
);
  portStrobe_t          strobe;
  logic [PTR_W-1:0]     ptrQ;
  logic [NUM_LOCKS-1:0] lockQ;

  nvram_port_ctrl #(
    .MEM_BYTES(MEM_BYTES), .NUM_LOCKS(NUM_LOCKS),
    .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .ptrQ(ptrQ),
    .lockToggle(lockToggle), .lockIdx(lockIdx), .lockQ(lockQ), .strobe(strobe)
  );

  nvram_port_dp #(.MEM_BYTES(MEM_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrData(wrData),
    .strobe(strobe), .ptrQ(ptrQ), .rdData(rdData)
  );
endmodule

// File: rtl/nvram_index_port_chk.sv
module nvram_index_port_chk #(
  parameter int NUM_LOCKS = 2,
  parameter int LOCK_BASE = 32,
  parameter int LOCK_SPAN = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [1:0]           portSel,
  input logic                 wrEn,
  input logic [7:0]           wrData,
  input logic [7:0]           rdData,
  input logic                 lockToggle,
  input logic [15:0]          ptrQ,
  input logic [NUM_LOCKS-1:0] lockQ
);
  logic inWin0;
  assign inWin0 = (32'(ptrQ) >= 32'(LOCK_BASE)) && (32'(ptrQ) < 32'(LOCK_BASE + LOCK_SPAN));

  AST_PTR_LOW_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'd0) |=> (ptrQ[7:0] == $past(wrData))); // R1
  AST_PTR_HIGH_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'd1) |=> (ptrQ[15:8] == $past(wrData))); // R1
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portSel == 2'd3) |=> (ptrQ == 16'h0000)); // R2
  AST_IDLE_READS_ONES: assert property (@(posedge clk) disable iff (!rstN)
    (portSel != 2'd3) |-> (rdData == 8'hFF)); // R3
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || portSel == 2'd2) |=> $stable(ptrQ)); // R4
  AST_LOCK0_READ: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ[0] && inWin0 && portSel == 2'd3) |-> (rdData == 8'hFF)); // R5
  AST_LOCK_ONE_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    lockToggle |=> ($countones(lockQ ^ $past(lockQ)) == 1)); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lockToggle |=> $stable(lockQ)); // R6
endmodule

bind nvram_index_port nvram_index_port_chk #(
  .NUM_LOCKS(NUM_LOCKS), .LOCK_BASE(LOCK_BASE), .LOCK_SPAN(LOCK_SPAN)
) u_chk (
  .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .lockToggle(lockToggle), .ptrQ(ptrQ), .lockQ(lockQ)
);

// File: tb/nvram_index_port_bench.sv
module nvram_index_port_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] portSel = 2'd2;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       lockToggle = 1'b0;
  logic [0:0] lockIdx = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nvram_index_port u_nvram_index_port (
    .clk(clk), .rstN(rstN), .portSel(portSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .lockToggle(lockToggle), .lockIdx(lockIdx)
  );

  // {sel, wr, chk, data, exp, tag}
  localparam int NV = 18;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 8'h10, 8'h00, 4'd1},  // R1 low byte 0x10
    {2'd1, 1'b1, 1'b0, 8'h00, 8'h00, 4'd1},  // R1 high byte 0x00
    {2'd3, 1'b1, 1'b0, 8'hA5, 8'h00, 4'd2},  // R2 store at 0x10
    {2'd3, 1'b1, 1'b0, 8'h3C, 8'h00, 4'd2},  // R2 pointer now 0
    {2'd3, 1'b0, 1'b1, 8'h00, 8'h3C, 4'd2},  // R2 byte 0 holds 3C
    {2'd0, 1'b1, 1'b0, 8'h10, 8'h00, 4'd1},  // R1
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hA5, 4'd3},  // R3 read 0x10
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hA5, 4'd9},  // R9 pointer kept
    {2'd2, 1'b1, 1'b0, 8'h77, 8'h00, 4'd4},  // R4 ignored write
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hA5, 4'd4},  // R4 pointer/mem intact
    {2'd2, 1'b0, 1'b1, 8'h00, 8'hFF, 4'd3},  // R3 slot 2 reads ones
    {2'd0, 1'b0, 1'b1, 8'h00, 8'hFF, 4'd3},  // R3 slot 0 reads ones
    {2'd1, 1'b1, 1'b0, 8'h01, 8'h00, 4'd8},  // R8 pointer 0x0110
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hFF, 4'd8},  // R8 out of range read
    {2'd3, 1'b1, 1'b0, 8'hEE, 8'h00, 4'd8},  // R8 dropped write
    {2'd3, 1'b0, 1'b1, 8'h00, 8'h3C, 4'd8},  // R8 byte 0 untouched
    {2'd0, 1'b1, 1'b0, 8'h10, 8'h00, 4'd1},  // R1 pointer 0x0010
    {2'd3, 1'b0, 1'b1, 8'h00, 8'hA5, 4'd8}   // R8 no wrap onto 0x10
  };

  task automatic drive(input logic [1:0] s, input logic w, input logic [7:0] d,
                       input logic tg, input logic ix);
    @(negedge clk);
    portSel = s; wrEn = w; wrData = d; lockToggle = tg; lockIdx = ix;
  endtask

  task automatic check(input logic [7:0] exp, input string tag);
    #1;
    nChecks++;
    if (rdData !== exp) begin
      nFails++;
      $display("FAIL %s: rdData=%02h expected=%02h", tag, rdData, exp);
    end
  endtask

  task automatic setPtr(input logic [15:0] a);
    drive(2'd0, 1'b1, a[7:0], 1'b0, 1'b0);
    drive(2'd1, 1'b1, a[15:8], 1'b0, 1'b0);
  endtask

  task automatic storeAt(input logic [15:0] a, input logic [7:0] d);
    setPtr(a);
    drive(2'd3, 1'b1, d, 1'b0, 1'b0);
  endtask

  task automatic readAt(input logic [15:0] a, input logic [7:0] exp, input string tag);
    setPtr(a);
    drive(2'd3, 1'b0, 8'h00, 1'b0, 1'b0);
    check(exp, tag);
  endtask

  task automatic toggle(input logic ix);
    drive(2'd2, 1'b0, 8'h00, 1'b1, ix);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    drive(2'd0, 1'b0, 8'h00, 1'b0, 1'b0);
    check(8'hFF, "R7 reset idle read");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][23:22], VEC[i][21], VEC[i][19:12], 1'b0, 1'b0);
      if (VEC[i][20]) begin
        #1;
        nChecks++;
        if (rdData !== VEC[i][11:4]) begin
          nFails++;
          $display("FAIL R%0d vector %0d: rdData=%02h expected=%02h",
                   VEC[i][3:0], i, rdData, VEC[i][11:4]);
        end
      end
    end

    // R5 / R6 lock windows
    storeAt(16'h0025, 8'h11);
    storeAt(16'h0035, 8'h22);
    storeAt(16'h001F, 8'h44);
    storeAt(16'h0040, 8'h33);
    toggle(1'b0);
    readAt(16'h0025, 8'hFF, "R5 locked window 0 read");
    readAt(16'h0035, 8'h22, "R5 window 1 still open");
    storeAt(16'h0025, 8'h99);
    drive(2'd3, 1'b0, 8'h00, 1'b0, 1'b0);
    check(8'h3C, "R5 dropped write clears pointer");
    toggle(1'b1);
    readAt(16'h0035, 8'hFF, "R5 locked window 1 read");
    readAt(16'h001F, 8'h44, "R5 below window edge");
    readAt(16'h0040, 8'h33, "R5 above window edge");
    toggle(1'b0);
    readAt(16'h0025, 8'h11, "R6 second toggle unlocks, old byte kept");

    // R7 / R10 reset with lock 1 set and pointer loaded
    setPtr(16'h0010);
    @(negedge clk); rstN = 1'b0; portSel = 2'd2; wrEn = 1'b0;
    @(negedge clk); rstN = 1'b1;
    drive(2'd3, 1'b0, 8'h00, 1'b0, 1'b0);
    check(8'h3C, "R7 pointer cleared by reset");
    readAt(16'h0035, 8'h22, "R7 locks cleared by reset");
    readAt(16'h0010, 8'hA5, "R10 memory kept through reset");

    drive(2'd2, 1'b0, 8'h00, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule